// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block is the host-facing register file of a real-time clock. It sits in a byte-wide memory space that the host reads and writes with a plain chip-select, write-enable, address and data port. The top eight byte addresses form a window of clock bytes. Every other address reaches an ordinary byte RAM. The window holds a control byte, followed by seconds, minutes, hours, weekday, day of month, month and year. All time fields are BCD on a 24-hour clock.

The bytes the host sees are snapshot copies. The running time lives in a separate set of BCD counters. Each pulse of a once-per-second tick from an external prescaler advances those counters. In the same clock edge, every snapshot byte takes the new time, unless the host has frozen the snapshot.

Two freeze bits exist. The read freeze holds the snapshot steady so that the host can read it without tearing, and the counters keep running underneath. The write freeze also holds the snapshot. While it is set, the host edits the snapshot bytes, and clearing the bit copies them into the counters. A stop bit in the seconds byte halts timekeeping altogether. A frequency-test enable bit in the weekday byte is kept as plain storage and brought out on a pin.

Top module: `rtc_calendar_bank`

## Requirements
- R1: After reset the window reads control 00h, seconds 80h (stop bit set), minutes 00h, hours 00h, weekday 01h, date 01h, month 01h, year 00h.
- R2: A read or write at an address whose bits 12..3 are not all ones goes to the byte RAM. A read returns the data combinationally in the cycle of the request. The RAM is indexed by the low RAM_AW address bits (10 by default), so address 0405h and address 0005h select the same byte.
- R3: Bits that carry no meaning always read 0. Writing FFh gives back: control FFh, seconds FFh, minutes 7Fh, hours 3Fh, weekday 47h, date 3Fh, month 1Fh, year FFh. Window offsets 0 to 7 hold control, seconds, minutes, hours, weekday, date, month and year.
- R4: When the stop bit (seconds bit 7) is 0 and neither freeze bit is set, a tick advances the counters by one second. All seven time bytes show the new time after that same clock edge.
- R5: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. At midnight the weekday steps, going from 07 to 01, and the date steps as well.
- R6: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months. In February it wraps after 28, or after 29 when the BCD year is divisible by 4 (00 counts as a leap year). Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: Control bit 6 (read freeze) set to 1 holds all seven time bytes while the counters keep running. The first tick after it is cleared shows the current count.
- R8: Control bit 7 (write freeze) set to 1 also holds the time bytes against ticks. A control write that clears bit 7 while it is 1 loads the time fields of the snapshot into the counters. The next tick shows the loaded time plus one second.
- R9: With the stop bit at 1, ticks change neither the counters nor the snapshot. After the bit is cleared, the next tick resumes counting from the held count.
- R10: The freeze test uses the control value held before the current edge. A tick in the same cycle as a control write that sets a freeze bit still completes its update. A host write to a time byte in the same cycle as an update wins for that byte.
- R11: Output ftest_en follows weekday bit 6. An update keeps weekday bit 6 and seconds bit 7 as the host last wrote them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (13) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of a read, 00h otherwise |
| ftest_en | output | 1 | Frequency-test enable from weekday bit 6 |

## Verification
A host write and a once-per-second update can land on the same clock edge. The snapshot rule has to decide which one counts. The bench makes this collision twice, using a task that raises the tick together with a write. In the first case, a control write sets the read freeze in that cycle. The bench checks that the seconds byte still advanced and that the following tick is held. In the second case, a minutes write lands on an unfrozen update. The bench checks that the written minutes byte survives while the seconds byte advances, and that the next update overwrites the minutes byte with the counter value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_BYTES = 8;
  localparam int IDX_W     = 3;
  localparam int NUM_FLD   = 7;
  localparam int TM_W      = 8 * NUM_FLD;

  // Field order matches window offsets 1..7 (sec in the low byte).
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [TM_W-1:0] TM_RESET = 56'h00_01_01_01_00_00_00;

  // Bits the host may hold in each window byte.
  function automatic logic [7:0] host_mask(input int idx);
    case (idx)
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h47;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // Bits an update must leave untouched (stop, frequency test).
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      1:       return 8'h80;
      4:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(input int idx);
    case (idx)
      1:       return 8'h80;
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // Lowest and highest value of each counter field (0 = sec ... 6 = year).
  function automatic logic [7:0] field_lo(input int fld);
    case (fld)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_hi(input int fld);
    case (fld)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return 8'h07;
      4:       return 8'h31;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic bcd_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
(
  input  logic [7:0] cur,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  input  logic       step,
  output logic [7:0] nxt,
  output logic       carry
);

  logic at_top;

  always_comb begin
    at_top = (cur >= hi);
    carry  = step & at_top;
    if (!step)       nxt = cur;
    else if (at_top) nxt = lo;
    else             nxt = bcd_inc(cur);
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic            load,
  input  logic [TM_W-1:0] load_tm,
  output logic [TM_W-1:0] tm_q,
  output logic [TM_W-1:0] tm_nxt,
  output logic            adv,
  output logic [NUM_FLD-1:0] carry
);

  rtc_time_t           cur_t;
  logic [7:0]          mday_hi;
  logic [NUM_FLD-1:0]  stp;
  logic [TM_W-1:0]     tm_d;
  logic                tm_en;

  assign cur_t   = tm_q;
  assign mday_hi = month_last(cur_t.mon, bcd_leap(cur_t.year));
  assign adv     = tick & run & ~load;

  // sec -> min -> hour -> {wday, mday} -> mon -> year
  assign stp = {carry[5], carry[4], carry[2], carry[2], carry[1], carry[0], adv};

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    localparam logic [7:0] LO = field_lo(f);
    localparam logic [7:0] HI = field_hi(f);
    logic [7:0] hi_sel;
    if (f == 4) begin : g_var
      assign hi_sel = mday_hi;
    end else begin : g_fix
      assign hi_sel = HI;
    end
    rtc_bcd_field u_fld (
      .cur  (tm_q[8*f +: 8]),
      .lo   (LO),
      .hi   (hi_sel),
      .step (stp[f]),
      .nxt  (tm_nxt[8*f +: 8]),
      .carry(carry[f])
    );
  end

  always_comb begin
    tm_en = load | adv;
    tm_d  = load ? load_tm : tm_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tm_q <= TM_RESET;
    else if (tm_en) tm_q <= tm_d;
  end

endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wdata,
  input  logic                   adv,
  input  logic [TM_W-1:0]        snap_tm,
  output logic [8*NUM_BYTES-1:0] vis_flat,
  output logic [TM_W-1:0]        load_tm,
  output logic                   load,
  output logic                   run,
  output logic                   frozen,
  output logic                   ftest
);

  logic snap_en;

  assign frozen  = vis_flat[7] | vis_flat[6];
  assign snap_en = adv & ~frozen;
  assign load    = wr_en & (wr_idx == '0) & ~wdata[7] & vis_flat[7];
  assign run     = ~vis_flat[15];
  assign ftest   = vis_flat[38];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [IDX_W-1:0] IX   = IDX_W'(i);
    localparam logic [7:0]       HM   = host_mask(i);
    localparam logic [7:0]       KM   = keep_mask(i);
    localparam logic [7:0]       RV   = reset_byte(i);
    localparam bit               IS_T = (i != 0);
    logic [7:0] q, d, snap_b;
    logic       en;

    if (i == 0) begin : g_ctl
      assign snap_b = 8'h00;
    end else begin : g_tm
      assign snap_b              = snap_tm[8*(i-1) +: 8];
      assign load_tm[8*(i-1) +: 8] = q & ~KM;
    end

    always_comb begin
      en = 1'b0;
      d  = q;
      if (wr_en && (wr_idx == IX)) begin
        en = 1'b1;
        d  = wdata & HM;
      end else if (snap_en && IS_T) begin
        en = 1'b1;
        d  = (snap_b & ~KM) | (q & KM);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV;
      else if (en) q <= d;
    end

    assign vis_flat[8*i +: 8] = q;
  end

endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] adr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[adr] <= wdata;
  end

  assign rdata = mem[adr];

endmodule

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ftest_en
);

  logic [1:0]             rst_pipe;
  logic                   rst_q_n;
  logic                   clk_hit;
  logic [IDX_W-1:0]       reg_idx;
  logic                   reg_wr, ram_we;
  logic [7:0]             ram_rd, win_rd;
  logic [8*NUM_BYTES-1:0] vis_flat;
  logic [TM_W-1:0]        live_tm, next_tm, load_tm;
  logic                   load_pulse, run, frozen, adv;
  logic [NUM_FLD-1:0]     fld_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign clk_hit = &addr[ADDR_W-1:IDX_W];
  assign reg_idx = addr[IDX_W-1:0];
  assign reg_wr  = cs & we & clk_hit;
  assign ram_we  = cs & we & ~clk_hit;

  rtc_byte_ram #(.AW(RAM_AW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .adr  (addr[RAM_AW-1:0]),
    .wdata(wdata),
    .rdata(ram_rd)
  );

  rtc_time_core u_core (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick   (tick_1hz),
    .run    (run),
    .load   (load_pulse),
    .load_tm(load_tm),
    .tm_q   (live_tm),
    .tm_nxt (next_tm),
    .adv    (adv),
    .carry  (fld_carry)
  );

  rtc_host_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (reg_wr),
    .wr_idx  (reg_idx),
    .wdata   (wdata),
    .adv     (adv),
    .snap_tm (next_tm),
    .vis_flat(vis_flat),
    .load_tm (load_tm),
    .load    (load_pulse),
    .run     (run),
    .frozen  (frozen),
    .ftest   (ftest_en)
  );

  assign win_rd = vis_flat[8*reg_idx +: 8];

  always_comb begin
    if (cs && !we) rdata = clk_hit ? win_rd : ram_rd;
    else           rdata = 8'h00;
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        cs,
  input logic        we,
  input logic        hit,
  input logic [2:0]  idx,
  input logic [7:0]  rdata,
  input logic [63:0] vis_flat,
  input logic [55:0] live_tm,
  input logic        load,
  input logic [55:0] load_tm,
  input logic        run,
  input logic        frozen,
  input logic [6:0]  fld_carry
);

  logic host_tm_wr;
  assign host_tm_wr = cs && we && hit;

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && hit && idx == 3'd4) |-> (rdata[7] == 1'b0 && rdata[5:3] == 3'd0));

  // R4
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load && !frozen && !host_tm_wr) |=> (vis_flat[14:8] == live_tm[6:0]));

  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_carry[3] |=> (live_tm[31:24] == 8'h01));

  // R6
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_carry[6] |=> (live_tm[55:48] == 8'h00));

  // R6
  mday_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_tm[39:32] != 8'h00) && (live_tm[47:40] != 8'h00));

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !host_tm_wr) |=> $stable(vis_flat[63:8]));

  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (live_tm == $past(load_tm)));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(live_tm));

endmodule

bind rtc_calendar_bank rtc_calendar_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .tick     (tick_1hz),
  .cs       (cs),
  .we       (we),
  .hit      (clk_hit),
  .idx      (reg_idx),
  .rdata    (rdata),
  .vis_flat (vis_flat),
  .live_tm  (live_tm),
  .load     (load_pulse),
  .load_tm  (load_tm),
  .run      (run),
  .frozen   (frozen),
  .fld_carry(fld_carry)
);

// File: tb/rtc_calendar_bank_tb.sv
module rtc_calendar_bank_tb;

  localparam logic [12:0] A_CTL  = 13'h1FF8;
  localparam logic [12:0] A_SEC  = 13'h1FF9;
  localparam logic [12:0] A_MIN  = 13'h1FFA;
  localparam logic [12:0] A_HOUR = 13'h1FFB;
  localparam logic [12:0] A_WDAY = 13'h1FFC;
  localparam logic [12:0] A_MDAY = 13'h1FFD;
  localparam logic [12:0] A_MON  = 13'h1FFE;
  localparam logic [12:0] A_YEAR = 13'h1FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ftest_en;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [12:0] a;
    logic [7:0]  d;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  rtc_calendar_bank u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1hz(tick),
    .cs      (cs),
    .we      (we),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .ftest_en(ftest_en)
  );

  // Monitor: pops one expected item for every read it sees.
  always begin
    exp_t e;
    @(negedge clk);
    #5;
    if (cs && !we) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL scoreboard empty addr=%h got=%h exp=none", addr, rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.d) begin
          bad++;
          $display("FAIL %s addr=%h got=%h exp=%h", e.tag, e.a, rdata, e.d);
        end
      end
    end
  end

  task automatic rd(input logic [12:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    e.a = a; e.d = d; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_tk(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d; tick = 1'b1;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic chk_ft(input logic e, input string tag);
    @(negedge clk);
    #5;
    total++;
    if (ftest_en !== e) begin
      bad++;
      $display("FAIL %s ftest_en got=%b exp=%b", tag, ftest_en, e);
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, md, mo, y);
    wr(A_CTL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HOUR, h); wr(A_WDAY, wd);
    wr(A_MDAY, md); wr(A_MON, mo); wr(A_YEAR, y);
    wr(A_CTL, 8'h00);
  endtask

  task automatic month_case(input logic [7:0] md, mo, y, emd, emo, ey, input string tag);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, md, mo, y);
    tk();
    rd(A_MDAY, emd, tag);
    rd(A_MON, emo, tag);
    rd(A_YEAR, ey, tag);
    rd(A_WDAY, 8'h04, tag);
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTL,  8'h00, "R1 ctrl");
    rd(A_SEC,  8'h80, "R1 sec");
    rd(A_MIN,  8'h00, "R1 min");
    rd(A_HOUR, 8'h00, "R1 hour");
    rd(A_WDAY, 8'h01, "R1 wday");
    rd(A_MDAY, 8'h01, "R1 mday");
    rd(A_MON,  8'h01, "R1 mon");
    rd(A_YEAR, 8'h00, "R1 year");
    chk_ft(1'b0, "R1 ftest");
    tk();
    rd(A_SEC, 8'h80, "R9 stopped at reset");

    // R2 plain RAM
    wr(13'h0005, 8'hA5);
    wr(13'h0123, 8'h3C);
    wr(13'h1FF7, 8'h5E);
    rd(13'h0005, 8'hA5, "R2 ram 0005");
    rd(13'h0123, 8'h3C, "R2 ram 0123");
    rd(13'h1FF7, 8'h5E, "R2 ram below window");
    wr(13'h0405, 8'h77);
    rd(13'h0005, 8'h77, "R2 alias");

    // R3 reserved bits, R11 frequency test bit
    wr(A_CTL, 8'hFF); rd(A_CTL, 8'hFF, "R3 ctrl");
    wr(A_CTL, 8'h00);
    wr(A_MIN, 8'hFF); rd(A_MIN, 8'h7F, "R3 min");
    wr(A_HOUR, 8'hFF); rd(A_HOUR, 8'h3F, "R3 hour");
    wr(A_WDAY, 8'hFF); rd(A_WDAY, 8'h47, "R3 wday");
    chk_ft(1'b1, "R11 ftest set");
    wr(A_WDAY, 8'h01);
    chk_ft(1'b0, "R11 ftest clear");
    wr(A_MDAY, 8'hFF); rd(A_MDAY, 8'h3F, "R3 mday");
    wr(A_MON, 8'hFF); rd(A_MON, 8'h1F, "R3 mon");
    wr(A_YEAR, 8'hFF); rd(A_YEAR, 8'hFF, "R3 year");

    // R8 write freeze and load, R5 full rollover
    wr(A_CTL, 8'h80);
    wr(A_SEC, 8'h58); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h23); wr(A_WDAY, 8'h07);
    wr(A_MDAY, 8'h31); wr(A_MON, 8'h12); wr(A_YEAR, 8'h99);
    tk();
    rd(A_SEC, 8'h58, "R8 held under write freeze");
    wr(A_CTL, 8'h00);
    rd(A_SEC, 8'h58, "R8 after load");
    tk();
    rd(A_SEC, 8'h59, "R8 loaded plus one");
    rd(A_MIN, 8'h59, "R8 min");
    tk();
    rd(A_SEC,  8'h00, "R5 sec wrap");
    rd(A_MIN,  8'h00, "R5 min wrap");
    rd(A_HOUR, 8'h00, "R5 hour wrap");
    rd(A_WDAY, 8'h01, "R5 wday wrap");
    rd(A_MDAY, 8'h01, "R6 dec31");
    rd(A_MON,  8'h01, "R6 month wrap");
    rd(A_YEAR, 8'h00, "R6 year 99 wrap");

    // R6 month lengths and leap years
    month_case(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21, "R6 apr30");
    month_case(8'h31, 8'h01, 8'h21, 8'h01, 8'h02, 8'h21, "R6 jan31");
    month_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R6 feb28 y23");
    month_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "R6 feb28 y24");
    month_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "R6 feb29 y24");
    month_case(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00, "R6 feb28 y00");
    month_case(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12, "R6 feb28 y12");
    month_case(8'h30, 8'h06, 8'h21, 8'h01, 8'h07, 8'h21, "R6 jun30");

    // R7 read freeze
    set_time(8'h00, 8'h00, 8'h10, 8'h02, 8'h05, 8'h06, 8'h21);
    wr(A_CTL, 8'h40);
    tk(); tk(); tk();
    rd(A_SEC, 8'h00, "R7 held");
    wr(A_CTL, 8'h00);
    rd(A_SEC, 8'h00, "R7 held until tick");
    tk();
    rd(A_SEC,  8'h04, "R7 resumed");
    rd(A_HOUR, 8'h10, "R7 hour");

    // R9 stop bit
    wr(A_SEC, 8'h80);
    tk(); tk();
    rd(A_SEC, 8'h80, "R9 stopped");
    wr(A_SEC, 8'h00);
    tk();
    rd(A_SEC, 8'h05, "R9 restart");

    // R10 same-cycle collisions
    wr_tk(A_CTL, 8'h40);
    rd(A_CTL, 8'h40, "R10 ctrl written");
    rd(A_SEC, 8'h06, "R10 update completed");
    tk();
    rd(A_SEC, 8'h06, "R10 freeze after update");
    wr(A_CTL, 8'h00);
    wr_tk(A_MIN, 8'h33);
    rd(A_SEC, 8'h08, "R10 sec with host write");
    rd(A_MIN, 8'h33, "R10 host wins");
    tk();
    rd(A_SEC, 8'h09, "R10 next update");
    rd(A_MIN, 8'h00, "R10 counter restored");

    // R11 preserved bits across update
    wr(A_WDAY, 8'h42);
    chk_ft(1'b1, "R11 ftest on");
    tk();
    rd(A_WDAY, 8'h42, "R11 ft kept by update");
    rd(A_SEC, 8'h10, "R4 update with ft");
    chk_ft(1'b1, "R11 ftest after update");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover got=%0d exp=0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule